// File: doc/BRIEF.md
# Serial-Bus Byte Memory Target

This block is a synthesizable stand-in for a 2048-byte serial memory that answers on an SPI bus as a target. A host selects it by pulling `cs_n` low, clocks in an 8-bit opcode on `si`, and then either streams bytes out of `so` (array reads, status reads) or streams bytes in (array writes, status writes). The storage is a plain register array. It starts at FFh after reset and keeps its contents only while powered.

Writes pass three gates. The first is a write-enable flag: a dedicated opcode sets it, and every write consumes it. The second is a protect input: when `wp_n` is low, it locks the top quarter of the array and the status byte. The third is a timed busy window that follows every accepted write. During that window the host can only poll the status byte. A hold input lets the host freeze the serial exchange in the middle of a byte and then continue from the same bit.

The block samples the bus pins with its own clock `clk`, which must run well above the serial clock rate. The busy window length is a parameter counted in `clk` cycles.

Top module: `spi_nvm_target`

## Requirements
- R1: SPI modes 0 and 3 both work. `si` is captured on rising `sck` edges and `so` changes only after falling `sck` edges, whatever level `sck` idles at.
- R2: While `cs_n` is high the target is deselected and `so_en` is 0. Each falling `cs_n` starts a fresh opcode. An opcode outside the six defined codes makes the target ignore the bus and keep `so_en` at 0 until `cs_n` rises.
- R3: The array holds 2048 bytes, each reset to FFh. READ (03h) and WRITE (02h) take a 16-bit address sent high byte first, and only address bits 10:0 select a byte.
- R4: WREN (06h) sets the write-enable flag and WRDI (04h) clears it. WRITE and WRSR (01h) that arrive with the flag clear change nothing and start no busy window.
- R5: With `wp_n` low, a WRITE aimed at 600h..7FFh and any WRSR are rejected, and the rejection clears the write-enable flag. Addresses below 600h stay writable.
- R6: RDSR (05h) returns the status byte repeatedly for as long as clocks continue. Bit 0 is busy, bit 1 is the write-enable flag, and bits 7:2 hold the field last written by WRSR (reset 0).
- R7: A WRITE commits only if `cs_n` rises after one or more whole data bytes with no partial byte. Successive bytes wrap inside the 16-byte page of the start address. A WRITE that ends any other way is dropped and clears the write-enable flag.
- R8: An accepted WRITE or WRSR sets busy for WRITE_CYCLES clock cycles. The write-enable flag stays set while busy and clears together with busy.
- R9: READ returns bytes from successive addresses, wrapping from 7FFh to 000h.
- R10: While busy, every opcode except RDSR is ignored. A READ drives nothing and a WRITE changes no byte.
- R11: While `hold_n` is low, `sck` edges are ignored and `so_en` is 0. When `hold_n` returns high, the transfer resumes at the bit where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Target select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Pause of the serial exchange, active low |
| wp_n | input | 1 | Write protect, active low |
| so | output | 1 | Serial data to the host |
| so_en | output | 1 | Output enable for `so`; 0 means high impedance |

## Verification
The bench writes pages with an arithmetic byte pattern, in both clock modes, and reads them back in one long sequential stream. A wrong page wrap or a missed address increment would therefore shift the whole stream. It writes across the end of a page and reads across the end of the array: a design that carries into the next page or stops at 7FFh returns the wrong bytes at the seam. It also ends writes on a partial byte, with no data at all, with the write-enable flag clear, during the busy window, and with `wp_n` low on both sides of 600h. A gate that leaked would show up as a changed byte, a busy bit or a write-enable flag left set. Finally, it asserts hold in the middle of a byte and toggles `sck`. A design that counted the held edges would return a shifted byte.

// File: rtl/spi_nvm_pkg.sv
`timescale 1ns/1ps
package spi_nvm_pkg;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_RDAT,
        PH_WDAT,
        PH_STAT,
        PH_WRSR,
        PH_SKIP
    } phase_t;
endpackage

// File: rtl/spi_nvm_sync.sv
`timescale 1ns/1ps
// Registers the bus pins into the clk domain and flags sck / cs_n edges.
module spi_nvm_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic cs_s,
    output logic si_s,
    output logic hold_s,
    output logic wp_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic sck_q, sck_p, cs_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_s   <= 1'b1;
            cs_p   <= 1'b1;
            sck_q  <= 1'b0;
            sck_p  <= 1'b0;
            si_s   <= 1'b0;
            hold_s <= 1'b1;
            wp_s   <= 1'b1;
        end else begin
            cs_s   <= cs_n;
            cs_p   <= cs_s;
            sck_q  <= sck;
            sck_p  <= sck_q;
            si_s   <= si;
            hold_s <= hold_n;
            wp_s   <= wp_n;
        end
    end

    assign sck_rise = sck_q & ~sck_p;
    assign sck_fall = ~sck_q & sck_p;
    assign cs_rise  = cs_s & ~cs_p;
endmodule

// File: rtl/spi_nvm_timer.sv
`timescale 1ns/1ps
// Busy window: high for exactly CYCLES clocks after a start pulse.
module spi_nvm_timer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int W = $clog2(CYCLES + 1);
    localparam logic [W-1:0] LAST = W'(CYCLES - 1);

    logic [W-1:0] cnt_q;
    logic         busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= LAST;
            end
        end else if (cnt_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/spi_nvm_array.sv
`timescale 1ns/1ps
// Byte array with one asynchronous read port and one masked page write port.
module spi_nvm_array #(
    parameter int AW = 11,
    parameter int PB = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           rd_addr,
    output logic [7:0]              rd_data,
    input  logic                    we,
    input  logic [AW-PB-1:0]        wr_page,
    input  logic [(1<<PB)*8-1:0]    wr_data,
    input  logic [(1<<PB)-1:0]      wr_mask
);
    localparam int DEPTH = 1 << AW;
    localparam int PAGE  = 1 << PB;

    logic [7:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam int               SLOT = g % PAGE;
        localparam logic [AW-PB-1:0] PNUM = (AW-PB)'(g >> PB);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[g] <= 8'hFF;
            else if (we && wr_page == PNUM && wr_mask[SLOT])
                mem_q[g] <= wr_data[SLOT*8 +: 8];
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/spi_nvm_target.sv
`timescale 1ns/1ps
module spi_nvm_target #(
    parameter int ADDR_BITS    = 11,
    parameter int PAGE_BITS    = 4,
    parameter int WRITE_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_en
);
    import spi_nvm_pkg::*;

    localparam int PAGE = 1 << PAGE_BITS;
    localparam int NPB  = ADDR_BITS - PAGE_BITS;

    typedef struct packed {
        phase_t                 ph;
        logic [3:0]             cnt;
        logic [15:0]            sh;
        logic [ADDR_BITS-1:0]   addr;
        logic                   is_wr;
        logic                   wel;
        logic [5:0]             user;
        logic [PAGE*8-1:0]      pbuf;
        logic [PAGE-1:0]        pmask;
        logic [PAGE_BITS-1:0]   poff;
        logic [NPB-1:0]         ppage;
        logic                   got;
        logic                   so;
    } regs_t;

    regs_t r_q, r_d;

    logic cs_s, si_s, hold_s, wp_s, sck_rise, sck_fall, cs_rise;
    logic busy, tmr_done, wr_go, arr_we, upper_pg;
    logic [7:0] rd_data, stat_byte;
    logic [15:0] rx;
    logic step, fall;

    spi_nvm_sync sync_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .cs_s(cs_s), .si_s(si_s),
        .hold_s(hold_s), .wp_s(wp_s), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .cs_rise(cs_rise)
    );

    spi_nvm_timer #(.CYCLES(WRITE_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .start(wr_go), .busy(busy), .done(tmr_done)
    );

    spi_nvm_array #(.AW(ADDR_BITS), .PB(PAGE_BITS)) array_i (
        .clk(clk), .rst_n(rst_n), .rd_addr(r_q.addr), .rd_data(rd_data),
        .we(arr_we), .wr_page(r_q.ppage), .wr_data(r_q.pbuf), .wr_mask(r_q.pmask)
    );

    assign upper_pg  = &r_q.ppage[NPB-1 -: 2];
    assign stat_byte = {r_q.user, r_q.wel, busy};
    assign rx        = {r_q.sh[14:0], si_s};
    assign step      = sck_rise && hold_s && !cs_s;
    assign fall      = sck_fall && hold_s && !cs_s;

    always_comb begin
        r_d    = r_q;
        wr_go  = 1'b0;
        arr_we = 1'b0;
        if (tmr_done)
            r_d.wel = 1'b0;

        if (cs_s) begin
            if (cs_rise) begin
                unique case (r_q.ph)
                    PH_WDAT: begin
                        if (r_q.cnt == 4'd0 && r_q.got && r_q.wel && !busy
                            && !(upper_pg && !wp_s)) begin
                            wr_go  = 1'b1;
                            arr_we = 1'b1;
                        end else begin
                            r_d.wel = 1'b0;
                        end
                    end
                    PH_WRSR: begin
                        if (r_q.cnt == 4'd0 && r_q.got && r_q.wel && !busy && wp_s) begin
                            wr_go    = 1'b1;
                            r_d.user = r_q.sh[7:2];
                        end else begin
                            r_d.wel = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            r_d.ph  = PH_IDLE;
            r_d.cnt = 4'd0;
        end else if (r_q.ph == PH_IDLE) begin
            r_d.ph    = PH_OPC;
            r_d.cnt   = 4'd0;
            r_d.got   = 1'b0;
            r_d.pmask = '0;
        end else if (step) begin
            r_d.sh  = rx;
            r_d.cnt = r_q.cnt + 4'd1;
            unique case (r_q.ph)
                PH_OPC: if (r_q.cnt == 4'd7) begin
                    r_d.cnt = 4'd0;
                    r_d.ph  = PH_SKIP;
                    if (rx[7:0] == OP_RDSR) begin
                        r_d.ph = PH_STAT;
                    end else if (!busy) begin
                        unique case (rx[7:0])
                            OP_WREN:  r_d.wel = 1'b1;
                            OP_WRDI:  r_d.wel = 1'b0;
                            OP_READ:  begin r_d.ph = PH_ADDR; r_d.is_wr = 1'b0; end
                            OP_WRITE: if (r_q.wel) begin r_d.ph = PH_ADDR; r_d.is_wr = 1'b1; end
                            OP_WRSR:  if (r_q.wel) r_d.ph = PH_WRSR;
                            default: ;
                        endcase
                    end
                end
                PH_ADDR: if (r_q.cnt == 4'd15) begin
                    r_d.cnt  = 4'd0;
                    r_d.addr = rx[ADDR_BITS-1:0];
                    if (r_q.is_wr) begin
                        r_d.ph    = PH_WDAT;
                        r_d.ppage = rx[ADDR_BITS-1:PAGE_BITS];
                        r_d.poff  = rx[PAGE_BITS-1:0];
                    end else begin
                        r_d.ph = PH_RDAT;
                    end
                end
                PH_RDAT: if (r_q.cnt == 4'd7) begin
                    r_d.cnt  = 4'd0;
                    r_d.addr = r_q.addr + 1'b1;
                end
                PH_WDAT: if (r_q.cnt == 4'd7) begin
                    r_d.cnt                          = 4'd0;
                    r_d.pbuf[{r_q.poff, 3'b000} +: 8] = rx[7:0];
                    r_d.pmask[r_q.poff]              = 1'b1;
                    r_d.poff                         = r_q.poff + 1'b1;
                    r_d.got                          = 1'b1;
                end
                PH_STAT, PH_WRSR: if (r_q.cnt == 4'd7) begin
                    r_d.cnt = 4'd0;
                    if (r_q.ph == PH_WRSR) r_d.got = 1'b1;
                end
                default: r_d.cnt = 4'd0;
            endcase
        end else if (fall) begin
            if (r_q.ph == PH_RDAT)
                r_d.so = rd_data[3'd7 - r_q.cnt[2:0]];
            else if (r_q.ph == PH_STAT)
                r_d.so = stat_byte[3'd7 - r_q.cnt[2:0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign so    = r_q.so;
    assign so_en = !cs_s && hold_s && (r_q.ph == PH_RDAT || r_q.ph == PH_STAT);
endmodule

// File: rtl/spi_nvm_chk.sv
`timescale 1ns/1ps
module spi_nvm_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic hold_n,
    input logic so_en,
    input logic busy,
    input logic wel,
    input logic wr_go,
    input logic arr_we,
    input logic upper_pg,
    input logic wp_s
);
    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !so_en);                                   // R2
    AST_HOLD_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!hold_n) |-> !so_en);                                // R11
    AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> wel);                                           // R4
    AST_PROTECTED_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && upper_pg) |-> wp_s);                            // R5
    AST_BUSY_KEEPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> wel);                                             // R8
    AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_go));                             // R8
    AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !arr_we);                                         // R10
endmodule

bind spi_nvm_target spi_nvm_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so_en(so_en),
    .busy(busy), .wel(r_q.wel), .wr_go(wr_go), .arr_we(arr_we),
    .upper_pg(upper_pg), .wp_s(wp_s)
);

// File: tb/spi_nvm_target_tb_top.sv
`timescale 1ns/1ps
module spi_nvm_target_tb_top;
    localparam int WC = 1000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_en;
    always #2.5 clk = ~clk;

    spi_nvm_target #(.WRITE_CYCLES(WC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_en(so_en)
    );

    int n_chk = 0, n_fail = 0;
    logic mode3 = 1'b0;
    logic [7:0] ref_mem [2048];
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [128];
    logic [7:0] st, d;

    task automatic tk(input int n); repeat (n) @(negedge clk); endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sel(); sck = mode3; tk(2); cs_n = 1'b0; tk(4); endtask
    task automatic desel(); if (!mode3) sck = 1'b0; tk(4); cs_n = 1'b1; tk(6); endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            sck = 1'b0; si = tx[b]; tk(4);
            rx[b] = so; sck = 1'b1; tk(4);
        end
    endtask

    task automatic tx8(input logic [7:0] tx); logic [7:0] x; xfer(tx, x); endtask
    task automatic cmd(input logic [7:0] op); sel(); tx8(op); desel(); endtask

    task automatic rdsr(output logic [7:0] s);
        sel(); tx8(8'h05); xfer(8'h00, s); desel();
    endtask

    task automatic wrsr(input logic [7:0] v); sel(); tx8(8'h01); tx8(v); desel(); endtask

    task automatic wr(input logic [15:0] a, input int n);
        sel(); tx8(8'h02); tx8(a[15:8]); tx8(a[7:0]);
        for (int i = 0; i < n; i++) tx8(wbuf[i]);
        desel();
    endtask

    task automatic rd(input logic [15:0] a, input int n);
        logic [7:0] x;
        sel(); tx8(8'h03); tx8(a[15:8]); tx8(a[7:0]);
        for (int i = 0; i < n; i++) begin xfer(8'h00, x); rbuf[i] = x; end
        desel();
    endtask

    task automatic model_wr(input int a, input int n);
        for (int i = 0; i < n; i++) ref_mem[(a & 'h7F0) | ((a + i) & 'hF)] = wbuf[i];
    endtask

    task automatic cmp_rd(input string tag, input int a, input int n);
        rd(16'(a), n);
        for (int i = 0; i < n; i++) chk(tag, rbuf[i], ref_mem[(a + i) & 'h7FF]);
    endtask

    task automatic wait_ready(); tk(WC + 20); endtask

    initial begin
        for (int i = 0; i < 2048; i++) ref_mem[i] = 8'hFF;
        tk(5); rst_n = 1'b1; tk(5);

        chk("R2 so_en low while deselected", so_en, 0);
        rdsr(st); chk("R6 status after reset", st, 8'h00);
        cmp_rd("R3 array erased after reset", 'h010, 2);

        // R4: write without enable flag
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        wr(16'h0010, 4);
        rdsr(st); chk("R4 no busy without WREN", st, 8'h00);
        cmp_rd("R4 data unchanged without WREN", 'h010, 4);
        cmd(8'h06); rdsr(st); chk("R4 WREN sets flag", st, 8'h02);
        cmd(8'h04); rdsr(st); chk("R4 WRDI clears flag", st, 8'h00);

        // R8 / R10: accepted write and busy window
        cmd(8'h06); wr(16'h0010, 4); model_wr('h010, 4);
        rdsr(st); chk("R8 busy and flag after commit", st, 8'h03);
        sel(); tx8(8'h03); tx8(8'h00); tx8(8'h10);
        sck = 1'b0; tk(4); chk("R10 READ ignored while busy", so_en, 0);
        desel();
        wbuf[0] = 8'h5A; wr(16'h0030, 1);
        wait_ready();
        rdsr(st); chk("R8 ready and flag cleared", st, 8'h00);
        cmp_rd("R7 page write data", 'h010, 4);
        cmp_rd("R10 WRITE ignored while busy", 'h030, 1);

        // R7: rollover within page
        cmd(8'h06);
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4;
        wr(16'h001E, 4); model_wr('h01E, 4); wait_ready();
        cmp_rd("R7 rollover inside page", 'h010, 16);

        // R7: partial byte abort
        cmd(8'h06);
        sel(); tx8(8'h02); tx8(8'h00); tx8(8'h40); tx8(8'h55);
        for (int b = 7; b >= 5; b--) begin sck = 1'b0; si = 1'b1; tk(4); sck = 1'b1; tk(4); end
        desel();
        rdsr(st); chk("R7 partial byte drops write", st, 8'h00);
        cmp_rd("R7 partial byte leaves data", 'h040, 1);
        cmd(8'h06);
        sel(); tx8(8'h02); tx8(8'h00); tx8(8'h50); desel();
        rdsr(st); chk("R7 write with no data dropped", st, 8'h00);

        // R5: protection
        wp_n = 1'b0;
        cmd(8'h06); wbuf[0] = 8'h77; wbuf[1] = 8'h88; wr(16'h0600, 2);
        rdsr(st); chk("R5 upper quarter rejected", st, 8'h00);
        cmp_rd("R5 upper quarter unchanged", 'h600, 2);
        cmd(8'h06); wr(16'h05F0, 2); model_wr('h5F0, 2);
        rdsr(st); chk("R5 below 600h accepted", st, 8'h03);
        wait_ready();
        cmp_rd("R5 below 600h data", 'h5F0, 2);
        cmd(8'h06); wrsr(8'hFC);
        rdsr(st); chk("R5 WRSR rejected under protect", st, 8'h00);
        wp_n = 1'b1;

        // R6: status field
        cmd(8'h06); wrsr(8'hA8);
        rdsr(st); chk("R6 status during WRSR cycle", st, 8'hAB);
        wait_ready();
        rdsr(st); chk("R6 status field stored", st, 8'hA8);
        cmd(8'h06); wrsr(8'h00); wait_ready();
        rdsr(st); chk("R6 status field restored", st, 8'h00);

        // R9: wrap at end of array, R3: high address bits ignored
        cmd(8'h06); wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; wr(16'h07FE, 2); model_wr('h7FE, 2);
        wait_ready();
        cmp_rd("R9 sequential read wraps", 'h7FE, 4);
        rd(16'hF810, 1); chk("R3 upper address bits ignored", rbuf[0], ref_mem['h010]);

        // R2: unknown opcode
        sel(); tx8(8'hAB); tx8(8'h00);
        sck = 1'b0; tk(4); chk("R2 unknown opcode keeps so off", so_en, 0);
        desel();
        rdsr(st); chk("R2 unknown opcode no effect", st, 8'h00);

        // R1: mode 3
        mode3 = 1'b1;
        cmd(8'h06); wbuf[0] = 8'h3C; wbuf[1] = 8'hC3; wbuf[2] = 8'h96;
        wr(16'h0070, 3); model_wr('h070, 3); wait_ready();
        cmp_rd("R1 mode 3 write and read", 'h070, 3);
        rdsr(st); chk("R1 mode 3 status", st, 8'h00);
        mode3 = 1'b0;
        cmp_rd("R1 mode 0 reads mode 3 data", 'h070, 3);

        // R11: hold in mid byte
        sel(); tx8(8'h03); tx8(8'h00); tx8(8'h10);
        d = 8'h00;
        for (int b = 7; b >= 0; b--) begin
            sck = 1'b0; si = 1'b0; tk(4);
            if (b == 4) begin
                hold_n = 1'b0; tk(3);
                chk("R11 so released during hold", so_en, 0);
                sck = 1'b1; tk(4); sck = 1'b0; tk(4); sck = 1'b1; tk(4); sck = 1'b0; tk(4);
                hold_n = 1'b1; tk(4);
            end
            d[b] = so; sck = 1'b1; tk(4);
        end
        chk("R11 byte intact across hold", d, ref_mem['h010]);
        xfer(8'h00, d); chk("R11 next byte after hold", d, ref_mem['h011]);
        desel();

        // Sweep: eight full pages, alternating modes, then one long read
        for (int p = 0; p < 8; p++) begin
            mode3 = p[0];
            for (int i = 0; i < 16; i++) wbuf[i] = 8'(((256 + p * 16 + i) * 7 + 3));
            cmd(8'h06); wr(16'(256 + p * 16), 16); model_wr(256 + p * 16, 16);
            wait_ready();
        end
        mode3 = 1'b0;
        cmp_rd("R3 R9 page sweep readback", 'h100, 128);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule